// File: doc/BRIEF.md
# Ping-Pong Buffer DMA Channel

This block is one DMA channel that moves data, one unit per peripheral request, between system memory and a peripheral FIFO. It holds two buffer descriptors. Each descriptor has its own start address, its own transfer count and its own 4-bit upper address field. The channel works through the active descriptor. When that descriptor's count runs out, the channel marks it done, retires it and switches to the other descriptor. Software can refill one buffer while the other is being drained, so a stream continues without interruption.

Software controls the channel through a 32-bit register port. The mode register is never written directly. A write to the set offset ORs ones into it, and a write to the clear offset removes ones from it, so flags can be updated one at a time without a read-modify-write. The mode register also holds the run control, a halt status that software polls after stopping, the interrupt enable and the device width. It holds several fields that are kept only for software: transfer size, bank, device ID, and the coherency and byte-order bits 8 and 13. Those fields have no effect on the channel. A transfer completes in the same cycle as its request: the channel raises the acknowledge and drives the memory port in that cycle.

Top module: `dbdmaChannel`

## Requirements
- R1: After reset, the mode register reads 0x0000_0040, with HALT (bit 6) set and every other bit clear. perAck, memEn and doneIrq are low.
- R2: A register write to offset 0x00 ORs the written bits into the mode register. A write to offset 0x04 clears every mode bit that is 1 in the written word. Bit 4 (active buffer) and bit 6 (HALT) ignore both kinds of write. Bits 31:20 always read 0, and a read of offset 0x00 returns the mode register.
- R3: A unit moves in a cycle when four conditions all hold: GO (bit 5) is set, the active buffer's enable bit is set (bit 0 for buffer 0, bit 2 for buffer 1), that buffer's count is nonzero, and perReq is high. In that cycle perAck and memEn are high and memAddr is {upper field, start address} of the active buffer. At the next edge the start address grows by the unit size and the count drops by 1. The unit size is set by width field bits 10:9: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and 3 is treated as 1 byte.
- R4: Direction bit 12 selects the data path. When it is 0, memory is read (memWe low) and perWdata carries memRdata. When it is 1, memory is written (memWe high) and memWdata carries perRdata.
- R5: A transfer can bring the active count to zero. At that edge the channel sets the buffer's done bit (bit 1 for buffer 0, bit 3 for buffer 1), clears its enable bit and toggles active bit 4. If the other buffer is enabled, the next cycle already transfers from it.
- R6: While GO is set and the active buffer is not enabled, perReq is never acknowledged. Transfers resume once software enables that buffer.
- R7: HALT reads 1 from the second cycle after a write clears GO. While GO is clear, no request is acknowledged. HALT returns to 0 at the same edge at which GO becomes set.
- R8: Each done bit is cleared on its own by writing a 1 in its position to offset 0x04. The other done bit is left as it was.
- R9: doneIrq is high exactly while interrupt enable (bit 7) is set and at least one done bit is set.
- R10: remainBytes equals the active buffer's count, multiplied by 2 for width code 1 and by 4 for width code 2.
- R11: If the active buffer is enabled with a count of zero while GO is set, it completes at the next edge without a transfer. Its done bit sets, its enable clears and the active bit toggles. No acknowledge is given in that cycle.
- R12: The registers read back as written. Offset 0x08 holds the peripheral FIFO address, which is driven on perFifoAddr. Offsets 0x0C and 0x14 hold the start addresses of buffers 0 and 1. Offsets 0x10 and 0x18 hold the counts, with the count in bits 15:0 and the upper address field in bits 19:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| perReq | input | 1 | Peripheral asks for one unit |
| perAck | output | 1 | Unit moved this cycle |
| perRdata | input | 32 | Data from the peripheral FIFO |
| perWdata | output | 32 | Data to the peripheral FIFO |
| perFifoAddr | output | 32 | Programmed peripheral FIFO address |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 36 | Memory byte address, upper field concatenated with start address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid in the access cycle |
| remainBytes | output | 18 | Bytes left in the active buffer |
| doneIrq | output | 1 | Done interrupt |

## Verification
The hardest case to bring about from the ports is the handover between buffers without a gap. The last unit of one buffer must be followed in the very next cycle by the first unit of the other buffer, with the new buffer's upper address field. The bench holds perReq high across the whole drain of two preloaded buffers and checks memAddr in every cycle. It then checks the idle cycle that follows, when neither buffer is enabled any more. The zero-count completion and the one-cycle lag of HALT after GO is cleared are also reached only by careful ordering. The bench times each register write so that the following sample falls in the exact cycle in which the status must change.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int MODE_W = 20;

  localparam logic [7:0] OFF_SET   = 8'h00;
  localparam logic [7:0] OFF_CLR   = 8'h04;
  localparam logic [7:0] OFF_FIFO  = 8'h08;
  localparam logic [7:0] OFF_BASE0 = 8'h0C;
  localparam logic [7:0] OFF_CNT0  = 8'h10;
  localparam logic [7:0] OFF_BASE1 = 8'h14;
  localparam logic [7:0] OFF_CNT1  = 8'h18;

  localparam int B_EN0   = 0;
  localparam int B_DONE0 = 1;
  localparam int B_EN1   = 2;
  localparam int B_DONE1 = 3;
  localparam int B_ACT   = 4;
  localparam int B_GO    = 5;
  localparam int B_HALT  = 6;
  localparam int B_IE    = 7;
  localparam int B_WLO   = 9;
  localparam int B_DIR   = 12;

  localparam logic [MODE_W-1:0] SW_MASK   = 20'hFFFAF;
  localparam logic [MODE_W-1:0] MODE_INIT = 20'h00040;

  typedef struct packed {
    logic       step;
    logic       stepBuf;
    logic [2:0] unitBytes;
    logic       wrFifo;
    logic [1:0] wrBase;
    logic [1:0] wrCnt;
  } dpStrobe_t;

  function automatic logic [1:0] widthShift(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dbdmaDatapath.sv
module dbdmaDatapath
  import dbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int UP_W   = 4,
  parameter int NBUF   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    dpCmd,
  input  logic [31:0]                  regWdata,
  input  logic                         actBuf,
  input  logic [1:0]                   unitShift,
  output logic [NBUF-1:0]              cntZero,
  output logic [NBUF-1:0]              cntOne,
  output logic [NBUF-1:0][ADDR_W-1:0]  baseQ,
  output logic [NBUF-1:0][CNT_W+UP_W-1:0] cntRegQ,
  output logic [ADDR_W-1:0]            fifoQ,
  output logic [UP_W+ADDR_W-1:0]       memAddr,
  output logic [CNT_W+1:0]             remainBytes
);
  localparam int CR_W = CNT_W + UP_W;

  logic [NBUF-1:0][ADDR_W-1:0] baseR;
  logic [NBUF-1:0][CNT_W-1:0]  cntR;
  logic [NBUF-1:0][UP_W-1:0]   upR;

  always_ff @(posedge clk) begin
    if (!rstN)           fifoQ <= '0;
    else if (dpCmd.wrFifo) fifoQ <= regWdata[ADDR_W-1:0];
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic stepHere;
    assign stepHere = dpCmd.step && (dpCmd.stepBuf == 1'(b));

    always_ff @(posedge clk) begin
      if (!rstN)                baseR[b] <= '0;
      else if (dpCmd.wrBase[b]) baseR[b] <= regWdata[ADDR_W-1:0];
      else if (stepHere)        baseR[b] <= baseR[b] + ADDR_W'(dpCmd.unitBytes);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntR[b] <= '0;
        upR[b]  <= '0;
      end else if (dpCmd.wrCnt[b]) begin
        cntR[b] <= regWdata[CNT_W-1:0];
        upR[b]  <= regWdata[CR_W-1:CNT_W];
      end else if (stepHere) begin
        cntR[b] <= cntR[b] - 1'b1;
      end
    end

    assign cntZero[b] = (cntR[b] == '0);
    assign cntOne[b]  = (cntR[b] == CNT_W'(1));
    assign baseQ[b]   = baseR[b];
    assign cntRegQ[b] = {upR[b], cntR[b]};

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!stepHere && !dpCmd.wrCnt[b]) |=> $stable(cntR[b]));
    // R5
    no_step_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
      stepHere |-> (cntR[b] != '0));
  end

  assign memAddr     = {upR[actBuf], baseR[actBuf]};
  assign remainBytes = {2'b00, cntR[actBuf]} << unitShift;
endmodule

// File: rtl/dbdmaCtrl.sv
module dbdmaCtrl
  import dbdma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             perReq,
  input  logic [1:0]       cntZero,
  input  logic [1:0]       cntOne,
  output logic [31:0]      modeQ,
  output dpStrobe_t        dpCmd,
  output logic             perAck,
  output logic             memEn,
  output logic             memWe,
  output logic             actBuf,
  output logic [1:0]       unitShift,
  output logic             doneIrq
);
  logic [MODE_W-1:0] modeR, hwMode, modeNext, setMask, clrMask;
  logic goNow, actEn, actZero, actLast, xferEv, finishEv, haltNext;

  assign actBuf    = modeR[B_ACT];
  assign goNow     = modeR[B_GO];
  assign actEn     = actBuf ? modeR[B_EN1] : modeR[B_EN0];
  assign actZero   = cntZero[actBuf];
  assign actLast   = cntOne[actBuf];
  assign xferEv    = goNow && actEn && !actZero && perReq;
  assign finishEv  = (goNow && actEn && actZero) || (xferEv && actLast);
  assign unitShift = widthShift(modeR[B_WLO+1:B_WLO]);

  always_comb begin
    hwMode = modeR;
    if (finishEv) begin
      if (actBuf) begin
        hwMode[B_DONE1] = 1'b1;
        hwMode[B_EN1]   = 1'b0;
      end else begin
        hwMode[B_DONE0] = 1'b1;
        hwMode[B_EN0]   = 1'b0;
      end
      hwMode[B_ACT] = ~actBuf;
    end
    setMask  = (regWr && regAddr == OFF_SET) ? (regWdata[MODE_W-1:0] & SW_MASK) : '0;
    clrMask  = (regWr && regAddr == OFF_CLR) ? (regWdata[MODE_W-1:0] & SW_MASK) : '0;
    modeNext = (hwMode | setMask) & ~clrMask;
    if (modeNext[B_GO])  haltNext = 1'b0;
    else if (!goNow)     haltNext = 1'b1;
    else                 haltNext = modeR[B_HALT];
    modeNext[B_HALT] = haltNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeR <= MODE_INIT;
    else       modeR <= modeNext;
  end

  always_comb begin
    dpCmd           = '0;
    dpCmd.step      = xferEv;
    dpCmd.stepBuf   = actBuf;
    dpCmd.unitBytes = 3'(1) << unitShift;
    dpCmd.wrFifo    = regWr && regAddr == OFF_FIFO;
    dpCmd.wrBase[0] = regWr && regAddr == OFF_BASE0;
    dpCmd.wrBase[1] = regWr && regAddr == OFF_BASE1;
    dpCmd.wrCnt[0]  = regWr && regAddr == OFF_CNT0;
    dpCmd.wrCnt[1]  = regWr && regAddr == OFF_CNT1;
  end

  assign modeQ   = 32'(modeR);
  assign perAck  = xferEv;
  assign memEn   = xferEv;
  assign memWe   = xferEv && modeR[B_DIR];
  assign doneIrq = modeR[B_IE] && (modeR[B_DONE0] || modeR[B_DONE1]);

  // R6
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeR[B_ACT] ? !modeR[B_EN1] : !modeR[B_EN0]) |-> !perAck);
  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> (perReq && modeR[B_GO]));
  // R7
  halt_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeR[B_GO] && $past(!modeR[B_GO])) |-> modeR[B_HALT]);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeR[B_DONE0] && !modeR[B_DONE1]) |-> !doneIrq);
endmodule

// File: rtl/dbdmaChannel.sv
module dbdmaChannel
  import dbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int UP_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [7:0]             regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic                   perReq,
  output logic                   perAck,
  input  logic [DATA_W-1:0]      perRdata,
  output logic [DATA_W-1:0]      perWdata,
  output logic [ADDR_W-1:0]      perFifoAddr,
  output logic                   memEn,
  output logic                   memWe,
  output logic [UP_W+ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [CNT_W+1:0]       remainBytes,
  output logic                   doneIrq
);
  localparam int NBUF = 2;

  dpStrobe_t dpCmd;
  logic [31:0] modeQ;
  logic actBuf;
  logic [1:0] unitShift;
  logic [NBUF-1:0] cntZero, cntOne;
  logic [NBUF-1:0][ADDR_W-1:0] baseQ;
  logic [NBUF-1:0][CNT_W+UP_W-1:0] cntRegQ;

  dbdmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .perReq(perReq), .cntZero(cntZero), .cntOne(cntOne),
    .modeQ(modeQ), .dpCmd(dpCmd), .perAck(perAck), .memEn(memEn),
    .memWe(memWe), .actBuf(actBuf), .unitShift(unitShift), .doneIrq(doneIrq)
  );

  dbdmaDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .UP_W(UP_W), .NBUF(NBUF)) u_dp (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .regWdata(regWdata),
    .actBuf(actBuf), .unitShift(unitShift), .cntZero(cntZero), .cntOne(cntOne),
    .baseQ(baseQ), .cntRegQ(cntRegQ), .fifoQ(perFifoAddr), .memAddr(memAddr),
    .remainBytes(remainBytes)
  );

  assign perWdata = memRdata;
  assign memWdata = perRdata;

  always_comb begin
    case (regAddr)
      OFF_SET:   regRdata = modeQ;
      OFF_FIFO:  regRdata = 32'(perFifoAddr);
      OFF_BASE0: regRdata = 32'(baseQ[0]);
      OFF_CNT0:  regRdata = 32'(cntRegQ[0]);
      OFF_BASE1: regRdata = 32'(baseQ[1]);
      OFF_CNT1:  regRdata = 32'(cntRegQ[1]);
      default:   regRdata = '0;
    endcase
  end

  // R2
  mode_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFF_SET) |-> (regRdata[31:20] == 12'h000));
endmodule

// File: tb/sim_dbdmaChannel.sv
module sim_dbdmaChannel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic perReq = 1'b0;
  logic perAck;
  logic [31:0] perRdata = '0;
  logic [31:0] perWdata;
  logic [31:0] perFifoAddr;
  logic memEn, memWe;
  logic [35:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic [17:0] remainBytes;
  logic doneIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign memRdata = memAddr[31:0] ^ 32'h5A5A_0000;

  dbdmaChannel u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .perReq(perReq), .perAck(perAck),
    .perRdata(perRdata), .perWdata(perWdata), .perFifoAddr(perFifoAddr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .remainBytes(remainBytes), .doneIrq(doneIrq)
  );

  // op, data, expected mode readback
  localparam logic [64:0] VECS [6] = '{
    {1'b0, 32'h0000_0081, 32'h0000_00C1},
    {1'b0, 32'h0000_0F00, 32'h0000_0FC1},
    {1'b0, 32'hFFF0_0050, 32'h0000_0FC1},
    {1'b1, 32'h0000_0300, 32'h0000_0CC1},
    {1'b0, 32'h000A_8000, 32'h000A_8CC1},
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0040}
  };

  task automatic endRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
      endRun();
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readNow(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    readNow(a, d);
  endtask

  initial begin
    logic [31:0] rd;
    logic [35:0] expAddr [5];
    expAddr = '{36'h3_0000_1000, 36'h3_0000_1002, 36'h3_0000_1004,
                36'h0_0000_2000, 36'h0_0000_2002};

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    regRead(8'h00, rd);
    chk("R1 mode after reset", rd, 32'h40);
    chk("R1 ack after reset", perAck, 0);
    chk("R1 memEn after reset", memEn, 0);
    chk("R1 irq after reset", doneIrq, 0);

    for (int i = 0; i < 6; i++) begin
      regWrite(VECS[i][64] ? 8'h04 : 8'h00, VECS[i][63:32]);
      regRead(8'h00, rd);
      chk("R2 set/clear vector", rd, VECS[i][31:0]);
    end

    regWrite(8'h0C, 32'h0000_1000);
    regWrite(8'h10, 32'h0003_0003);
    regWrite(8'h14, 32'h0000_2000);
    regWrite(8'h18, 32'h0000_0002);
    regWrite(8'h08, 32'h000D_EAD0);
    regRead(8'h10, rd); chk("R12 count0 readback", rd, 32'h0003_0003);
    regRead(8'h14, rd); chk("R12 start1 readback", rd, 32'h0000_2000);
    regRead(8'h08, rd); chk("R12 fifo readback", rd, 32'h000D_EAD0);
    chk("R12 fifo port", perFifoAddr, 32'h000D_EAD0);

    regWrite(8'h00, 32'h0000_02A5);
    readNow(8'h00, rd);
    chk("R7 halt clears with go", rd, 32'h0000_02A5);
    chk("R10 remain 16-bit", remainBytes, 18'd6);

    @(negedge clk);
    perReq = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk("R3 ack in drain", perAck, 1);
      chk("R5 address across handover", memAddr, expAddr[i]);
      chk("R4 read direction", {memWe, perWdata}, {1'b0, expAddr[i][31:0] ^ 32'h5A5A_0000});
    end
    @(negedge clk); #1;
    chk("R6 idle after both done", perAck, 0);
    perReq = 1'b0;
    regRead(8'h00, rd);
    chk("R5 mode after both done", rd, 32'h0000_02AA);
    chk("R9 irq with done", doneIrq, 1);
    regRead(8'h10, rd); chk("R3 count0 drained", rd, 32'h0003_0000);
    regRead(8'h0C, rd); chk("R3 start0 stepped", rd, 32'h0000_1006);

    regWrite(8'h04, 32'h0000_0002);
    readNow(8'h00, rd);
    chk("R8 clear done0 only", rd, 32'h0000_02A8);
    chk("R9 irq with done1", doneIrq, 1);
    regWrite(8'h04, 32'h0000_0008);
    readNow(8'h00, rd);
    chk("R8 clear done1", rd, 32'h0000_02A0);
    chk("R9 irq no done", doneIrq, 0);

    regWrite(8'h10, 32'h0000_0002);
    regWrite(8'h0C, 32'h0000_3000);
    perReq = 1'b1;
    #1; chk("R6 no enable no ack", perAck, 0);
    @(negedge clk); #1; chk("R6 still idle", perAck, 0);
    perReq = 1'b0;
    regWrite(8'h04, 32'h0000_0200);
    regWrite(8'h00, 32'h0000_1401);
    readNow(8'h00, rd);
    chk("R2 mode for write dir", rd, 32'h0000_14A1);
    chk("R10 remain 32-bit", remainBytes, 18'd8);
    perRdata = 32'h1234_5678;
    perReq = 1'b1;
    #1;
    chk("R6 resumes after enable", perAck, 1);
    chk("R4 write direction", {memWe, memWdata}, {1'b1, 32'h1234_5678});
    chk("R3 addr unit 0", memAddr, 36'h0_0000_3000);
    @(negedge clk); #1;
    chk("R3 addr step 4", memAddr, 36'h0_0000_3004);
    @(negedge clk); #1;
    chk("R6 idle other disabled", perAck, 0);
    perReq = 1'b0;
    readNow(8'h00, rd);
    chk("R5 toggle to buffer1", rd, 32'h0000_14B2);
    regWrite(8'h04, 32'h0000_0002);

    regWrite(8'h18, 32'h0000_0005);
    regWrite(8'h00, 32'h0000_0004);
    regWrite(8'h04, 32'h0000_0020);
    readNow(8'h00, rd);
    chk("R7 halt lags go clear", rd, 32'h0000_1494);
    @(negedge clk);
    readNow(8'h00, rd);
    chk("R7 halt set", rd, 32'h0000_14D4);
    perReq = 1'b1;
    #1; chk("R7 no ack while stopped", perAck, 0);
    chk("R10 remain buffer1", remainBytes, 18'd20);

    regWrite(8'h18, 32'h0000_0000);
    regWrite(8'h00, 32'h0000_0020);
    readNow(8'h00, rd);
    chk("R11 go with empty buffer", rd, 32'h0000_14B4);
    chk("R11 no ack on empty", perAck, 0);
    @(negedge clk);
    readNow(8'h00, rd);
    chk("R11 empty completes", rd, 32'h0000_14A8);
    chk("R11 still no ack", perAck, 0);
    perReq = 1'b0;

    endRun();
  end
endmodule